// File: doc/BRIEF.md
# Host-Mastered DMA Slave Port

This block lets an external host move 16-bit words into or out of the local system. The host drives an asynchronous, memory-style strobe interface: an active-low chip select, separate active-low read and write strobes, a select line and a 16-bit data bus. The select line chooses between the data path and the control path. On the control path a write loads the port configuration and a read returns a status word. On the data path accesses go through a small word FIFO whose far side is a valid/ready request interface to the local DMA engine.

The port is half duplex. One configuration bit sets the direction. Inbound transfers go from the host to the local side. Outbound transfers go from the local side to the host. The host bus is 16 bits wide, or 8 bits wide with two accesses packed into each FIFO word in a selectable byte order. There are two flow-control modes. In acknowledge mode a data access that cannot complete pulls the acknowledge output low until the FIFO can take it. In interrupt mode the acknowledge output stays high. The port instead raises an interrupt when a whole FIFO-depth burst can complete: the FIFO is empty for inbound, or full for outbound. A local enable input gates all data movement.

Top module: `hport_slave`

## Requirements
- R1: After reset the configuration is all zero (inbound, 16-bit, little-endian, acknowledge mode). The FIFO is empty, the error flag is clear, and `m_valid_o` and `hirq_o` are low.
- R2: Each host access is taken on the trailing (rising) edge of the write or read strobe while chip select is low. An inbound 16-bit data write pushes one word, and words reach `m_data_o` in write order under valid/ready.
- R3: In 8-bit mode (configuration bit 1 set) two inbound byte writes, taken from `hdata_i[7:0]`, form one word. The first byte is the low byte when bit 2 is clear (little-endian) and the high byte when bit 2 is set (big-endian). No word is pushed after the first byte alone.
- R4: Outbound (configuration bit 0 set), the local side pushes words through `s_valid_i`/`s_ready_o`. In 16-bit mode each host data read returns and removes the head word. In 8-bit mode reads return the low byte and then the high byte in little-endian order, the reverse in big-endian order, with the upper byte of `hdata_o` zero. The word is removed after the second read.
- R5: Half duplex: inbound, `s_ready_o` is low and host data reads are ignored. Outbound, `m_valid_o` is low and host data writes are ignored. Ignored accesses change neither the fill level nor the error flag.
- R6: In acknowledge mode (configuration bit 3 clear) `hack_o` is low during an inbound data write while the FIFO is full, and during an outbound data read while the FIFO is empty. It is high for every other access.
- R7: In interrupt mode (configuration bit 3 set) `hack_o` stays high. `hirq_o` is high exactly when the port is enabled and either inbound with the FIFO empty or outbound with the FIFO full.
- R8: A host read with `hsel_i` high returns the status word: bits 7:0 the FIFO fill level, bit 8 the direction, bit 9 the enable input, bit 10 the error flag, all other bits zero.
- R9: A data write that would push into a full FIFO drops the word. A data read from an empty FIFO removes nothing. Either one sets the sticky error flag. A configuration write clears the error flag, empties the FIFO and restarts byte packing.
- R10: With `port_en_i` low, host data accesses are ignored, and `m_valid_o`, `s_ready_o` and `hirq_o` stay low. Configuration writes and status reads still work.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_en_i | input | 1 | Local enable bit for data movement |
| hcs_ni | input | 1 | Host chip select, active low |
| hwr_ni | input | 1 | Host write strobe, active low |
| hrd_ni | input | 1 | Host read strobe, active low |
| hsel_i | input | 1 | 1 selects configuration/status, 0 selects data |
| hdata_i | input | 16 | Host write data |
| hdata_o | output | 16 | Host read data |
| hdata_oe_o | output | 1 | Drive enable for the host data bus |
| hack_o | output | 1 | Access acknowledge, low stalls the host |
| hirq_o | output | 1 | Burst-ready interrupt to the host |
| m_valid_o | output | 1 | Inbound word available to local side |
| m_data_o | output | 16 | Inbound word |
| m_ready_i | input | 1 | Local side takes the inbound word |
| s_valid_i | input | 1 | Local side offers an outbound word |
| s_data_i | input | 16 | Outbound word |
| s_ready_o | output | 1 | Port accepts the outbound word |

## Verification
The assertions assume the host obeys the strobe timing. Chip select encloses each strobe. Select and write data stay stable from strobe start until at least four local clocks after its trailing edge. Consecutive accesses are spaced so that the previous one has been taken before the next strobe begins. They also assume the local side never pushes while `s_ready_o` is low. The bench respects all of this by construction. Every host access is a task that holds the strobe three cycles, leaves the data lines untouched afterwards and then idles six cycles. Local pushes are made only when `s_ready_o` is known to be high.

// File: rtl/hport_pkg.sv
package hport_pkg;
  localparam int HW = 16;

  // bit0 dir_out, bit1 bus8, bit2 big_end, bit3 irq_mode
  typedef struct packed {
    logic irq_mode;
    logic big_end;
    logic bus8;
    logic dir_out;
  } hcfg_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic done_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], act_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  // trailing edge of the synchronised strobe
  assign done_o = last_q & ~chain_q[STAGES-1];

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
endmodule

// File: rtl/hport_fifo.sv
module hport_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [LVL_W-1:0] cnt_q;

  assign full_o  = (cnt_q == LVL_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign level_o = cnt_q;
  assign rdata_o = mem_q[rptr_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
      if (pop_i)  rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R9
  AST_LEVEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(flush_i) |-> (level_o == $past(level_o) || level_o == $past(level_o) + 1'b1
                         || level_o == $past(level_o) - 1'b1)); // R2
endmodule

// File: rtl/hport_bytes.sv
module hport_bytes #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         bus8_i,
  input  logic         big_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_i,
  input  logic [W-1:0] head_i,
  output logic         push_o,
  output logic [W-1:0] pword_o,
  output logic         pop_o,
  output logic [W-1:0] rdata_o
);
  localparam int B = W / 2;

  logic         phase_q;
  logic [B-1:0] first_q;
  logic         sel_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      first_q <= '0;
    end else if (clr_i) begin
      phase_q <= 1'b0;
    end else if (bus8_i && wr_i) begin
      if (!phase_q) first_q <= wdata_i[B-1:0];
      phase_q <= ~phase_q;
    end else if (bus8_i && rd_i) begin
      phase_q <= ~phase_q;
    end
  end

  assign push_o = wr_i & (~bus8_i | phase_q);
  assign pop_o  = rd_i & (~bus8_i | phase_q);

  always_comb begin
    if (!bus8_i)     pword_o = wdata_i;
    else if (big_i)  pword_o = {first_q, wdata_i[B-1:0]};
    else             pword_o = {wdata_i[B-1:0], first_q};
  end

  // byte lane served by this read: first lane is low for little-endian
  assign sel_hi  = big_i ^ phase_q;
  assign rdata_o = !bus8_i ? head_i
                 : {{B{1'b0}}, sel_hi ? head_i[W-1:B] : head_i[B-1:0]};
endmodule

// File: rtl/hport_slave.sv
module hport_slave #(
  parameter int DEPTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        port_en_i,
  input  logic        hcs_ni,
  input  logic        hwr_ni,
  input  logic        hrd_ni,
  input  logic        hsel_i,
  input  logic [15:0] hdata_i,
  output logic [15:0] hdata_o,
  output logic        hdata_oe_o,
  output logic        hack_o,
  output logic        hirq_o,
  output logic        m_valid_o,
  output logic [15:0] m_data_o,
  input  logic        m_ready_i,
  input  logic        s_valid_i,
  input  logic [15:0] s_data_i,
  output logic        s_ready_o
);
  import hport_pkg::*;

  localparam int LVL_W = $clog2(DEPTH + 1);

  hcfg_t          cfg_q;
  logic           err_q;
  logic           wr_done, rd_done;
  logic           cfg_wr, dat_wr, dat_rd, rd_ok;
  logic           b_push, b_pop;
  logic [HW-1:0]  b_pword, b_rdata, head;
  logic           f_push, f_pop, full, empty;
  logic [HW-1:0]  f_wdata;
  logic [LVL_W-1:0] level;
  logic [HW-1:0]  status;
  logic           overflow, underflow;

  hport_sync #(.STAGES(SYNC_STAGES)) u_sync_wr (
    .clk_i, .rst_ni, .act_i(~hcs_ni & ~hwr_ni), .done_o(wr_done));
  hport_sync #(.STAGES(SYNC_STAGES)) u_sync_rd (
    .clk_i, .rst_ni, .act_i(~hcs_ni & ~hrd_ni), .done_o(rd_done));

  assign cfg_wr = wr_done & hsel_i;
  assign dat_wr = wr_done & ~hsel_i & port_en_i & ~cfg_q.dir_out;
  assign dat_rd = rd_done & ~hsel_i & port_en_i &  cfg_q.dir_out;
  assign rd_ok  = dat_rd & ~empty;

  assign overflow  = b_push & full;
  assign underflow = dat_rd & empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (cfg_wr) begin
      cfg_q <= hcfg_t'(hdata_i[3:0]);
      err_q <= 1'b0;
    end else if (overflow || underflow) begin
      err_q <= 1'b1;
    end
  end

  hport_bytes #(.W(HW)) u_bytes (
    .clk_i, .rst_ni,
    .clr_i   (cfg_wr),
    .bus8_i  (cfg_q.bus8),
    .big_i   (cfg_q.big_end),
    .wr_i    (dat_wr),
    .wdata_i (hdata_i),
    .rd_i    (rd_ok),
    .head_i  (head),
    .push_o  (b_push),
    .pword_o (b_pword),
    .pop_o   (b_pop),
    .rdata_o (b_rdata));

  assign s_ready_o = port_en_i &  cfg_q.dir_out & ~full;
  assign m_valid_o = port_en_i & ~cfg_q.dir_out & ~empty;
  assign m_data_o  = head;

  assign f_push  = cfg_q.dir_out ? (s_valid_i & s_ready_o) : (b_push & ~full);
  assign f_wdata = cfg_q.dir_out ? s_data_i : b_pword;
  assign f_pop   = cfg_q.dir_out ? b_pop : (m_valid_o & m_ready_i);

  hport_fifo #(.DEPTH(DEPTH), .W(HW), .LVL_W(LVL_W)) u_fifo (
    .clk_i, .rst_ni,
    .flush_i (cfg_wr),
    .push_i  (f_push),
    .wdata_i (f_wdata),
    .pop_i   (f_pop),
    .rdata_o (head),
    .level_o (level),
    .full_o  (full),
    .empty_o (empty));

  assign status = {5'b0, err_q, port_en_i, cfg_q.dir_out, 8'(level)};

  assign hdata_o    = hsel_i ? status : b_rdata;
  assign hdata_oe_o = ~hcs_ni & ~hrd_ni;

  // stall only a data access the FIFO cannot serve, and only in handshake mode
  assign hack_o = ~(~cfg_q.irq_mode & ~hsel_i & port_en_i &
                    ((~hwr_ni & ~cfg_q.dir_out & full) |
                     (~hrd_ni &  cfg_q.dir_out & empty)));

  assign hirq_o = port_en_i & cfg_q.irq_mode & (cfg_q.dir_out ? full : empty);

  AST_HALF_DUPLEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_valid_o && s_ready_o)); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (!m_valid_o && !s_ready_o && !hirq_o)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(err_q) && !$past(cfg_wr)) |-> err_q); // R9
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_wr |=> (level == '0)); // R9
  AST_IRQ_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hirq_o |-> (cfg_q.dir_out ? (level == LVL_W'(DEPTH)) : (level == '0))); // R7
endmodule

// File: tb/hport_slave_bench.sv
`timescale 1ns/1ps
module hport_slave_bench;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        port_en_i = 1'b0;
  logic        hcs_ni = 1'b1, hwr_ni = 1'b1, hrd_ni = 1'b1, hsel_i = 1'b0;
  logic [15:0] hdata_i = '0;
  logic [15:0] hdata_o, m_data_o;
  logic        hdata_oe_o, hack_o, hirq_o, m_valid_o, s_ready_o;
  logic        m_ready_i = 1'b0, s_valid_i = 1'b0;
  logic [15:0] s_data_i = '0;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  hport_slave #(.DEPTH(DEPTH)) u_hport_slave (
    .clk_i(clk), .rst_ni, .port_en_i, .hcs_ni, .hwr_ni, .hrd_ni, .hsel_i,
    .hdata_i, .hdata_o, .hdata_oe_o, .hack_o, .hirq_o, .m_valid_o, .m_data_o,
    .m_ready_i, .s_valid_i, .s_data_i, .s_ready_o);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic sel, input logic [15:0] d, output logic ack);
    @(negedge clk);
    hsel_i = sel; hdata_i = d; hcs_ni = 1'b0; hwr_ni = 1'b0;
    repeat (3) @(negedge clk);
    ack = hack_o;
    hwr_ni = 1'b1; hcs_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic host_read(input logic sel, output logic [15:0] d, output logic ack);
    @(negedge clk);
    hsel_i = sel; hcs_ni = 1'b0; hrd_ni = 1'b0;
    repeat (3) @(negedge clk);
    d = hdata_o; ack = hack_o;
    hrd_ni = 1'b1; hcs_ni = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic cfg(input logic [3:0] c);
    logic a;
    host_write(1'b1, {12'h0, c}, a);
  endtask

  task automatic status_is(input string tag, input logic [15:0] exp);
    logic [15:0] d; logic a;
    host_read(1'b1, d, a);
    check(tag, d, exp);
  endtask

  task automatic local_pop(input string tag, input logic [15:0] exp);
    @(negedge clk);
    check({tag, " valid"}, 16'(m_valid_o), 16'h1);
    check(tag, m_data_o, exp);
    m_ready_i = 1'b1;
    @(negedge clk);
    m_ready_i = 1'b0;
  endtask

  task automatic local_push(input logic [15:0] d);
    @(negedge clk);
    s_valid_i = 1'b1; s_data_i = d;
    @(negedge clk);
    s_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 m_valid", 16'(m_valid_o), 16'h0);
    check("R1 hirq", 16'(hirq_o), 16'h0);
    status_is("R1 status", 16'h0000);
  endtask

  task automatic t_in16;
    logic a;
    port_en_i = 1'b1;
    cfg(4'h0);
    host_write(1'b0, 16'h1234, a);
    check("R6 ack not full", 16'(a), 16'h1);
    host_write(1'b0, 16'hBEEF, a);
    host_write(1'b0, 16'h0F0F, a);
    status_is("R8 status level3", 16'h0203);
    local_pop("R2 word0", 16'h1234);
    local_pop("R2 word1", 16'hBEEF);
    local_pop("R2 word2", 16'h0F0F);
    status_is("R2 drained", 16'h0200);
  endtask

  task automatic t_in8;
    logic a;
    cfg(4'h2);
    host_write(1'b0, 16'hAA11, a);
    status_is("R3 half word not pushed", 16'h0200);
    host_write(1'b0, 16'hBB22, a);
    local_pop("R3 little-endian pack", 16'h2211);
    cfg(4'h6);
    host_write(1'b0, 16'h0033, a);
    host_write(1'b0, 16'h0044, a);
    local_pop("R3 big-endian pack", 16'h3344);
  endtask

  task automatic t_out;
    logic [15:0] d; logic a;
    cfg(4'h1);
    local_push(16'hA1B2);
    local_push(16'hC3D4);
    host_read(1'b0, d, a); check("R4 read16 w0", d, 16'hA1B2);
    host_read(1'b0, d, a); check("R4 read16 w1", d, 16'hC3D4);
    cfg(4'h3);
    local_push(16'h5566);
    host_read(1'b0, d, a); check("R4 LE byte0", d, 16'h0066);
    status_is("R4 not popped after one byte", 16'h0301);
    host_read(1'b0, d, a); check("R4 LE byte1", d, 16'h0055);
    cfg(4'h7);
    local_push(16'h7788);
    host_read(1'b0, d, a); check("R4 BE byte0", d, 16'h0077);
    host_read(1'b0, d, a); check("R4 BE byte1", d, 16'h0088);
    status_is("R4 drained", 16'h0300);
  endtask

  task automatic t_duplex;
    logic [15:0] d; logic a;
    cfg(4'h1);
    @(negedge clk);
    check("R5 outbound m_valid", 16'(m_valid_o), 16'h0);
    check("R5 outbound s_ready", 16'(s_ready_o), 16'h1);
    host_write(1'b0, 16'h9999, a);
    status_is("R5 write ignored outbound", 16'h0300);
    cfg(4'h0);
    @(negedge clk);
    check("R5 inbound s_ready", 16'(s_ready_o), 16'h0);
    host_read(1'b0, d, a);
    status_is("R5 read ignored inbound", 16'h0200);
  endtask

  task automatic t_ack_err;
    logic [15:0] d; logic a;
    cfg(4'h0);
    for (int i = 0; i < DEPTH; i++) host_write(1'b0, 16'(i + 16'h100), a);
    status_is("R6 full level", 16'h0200 | 16'(DEPTH));
    host_write(1'b0, 16'hDEAD, a);
    check("R6 ack low on full write", 16'(a), 16'h0);
    status_is("R9 overflow error", 16'h0600 | 16'(DEPTH));
    local_pop("R9 overflow dropped, head intact", 16'h0100);
    cfg(4'h0);
    status_is("R9 config clears", 16'h0200);
    cfg(4'h1);
    host_read(1'b0, d, a);
    check("R6 ack low on empty read", 16'(a), 16'h0);
    status_is("R9 underflow error", 16'h0700);
  endtask

  task automatic t_irq;
    logic [15:0] d; logic a;
    cfg(4'h8);
    @(negedge clk);
    check("R7 irq inbound empty", 16'(hirq_o), 16'h1);
    host_write(1'b0, 16'h4242, a);
    check("R7 irq drops", 16'(hirq_o), 16'h0);
    cfg(4'h9);
    @(negedge clk);
    check("R7 irq outbound empty", 16'(hirq_o), 16'h0);
    host_read(1'b0, d, a);
    check("R7 ack high in irq mode", 16'(a), 16'h1);
    for (int i = 0; i < DEPTH - 1; i++) local_push(16'(i));
    @(negedge clk);
    check("R7 irq not yet full", 16'(hirq_o), 16'h0);
    local_push(16'h00FF);
    @(negedge clk);
    check("R7 irq outbound full", 16'(hirq_o), 16'h1);
  endtask

  task automatic t_disable;
    logic a;
    port_en_i = 1'b0;
    cfg(4'h8);
    @(negedge clk);
    check("R10 irq gated", 16'(hirq_o), 16'h0);
    host_write(1'b0, 16'h5A5A, a);
    status_is("R10 write ignored", 16'h0000);
    check("R10 m_valid low", 16'(m_valid_o), 16'h0);
    port_en_i = 1'b1;
    @(negedge clk);
    check("R10 irq back", 16'(hirq_o), 16'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_in16();
    t_in8();
    t_out();
    t_duplex();
    t_ack_err();
    t_irq();
    t_disable();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule